// File: doc/BRIEF.md
# Source-Port Mapper with Per-Class and Per-Source Traffic Counters

This block sits on the packet status path. For each start-of-packet strobe it takes the source port and traffic class that come with the packet and looks the source port up in a 256-entry mapping table. The table entry picks one of four destination ports. It also holds a per-source switch. When the switch is clear, the class from the status word passes through. When it is set, the class stored in the table replaces it. The chosen port and class appear on registered outputs one clock after the strobe.

Every counted packet updates four counters. A packet counter and a byte counter are kept for each destination-port and class pair (sixteen pairs, 32 bits each). A wide byte counter (48 bits) and a wide packet counter (40 bits) are kept for each source port. Byte counters add the packet-length field and packet counters add one. After reset, a sequencer clears one counter slot per clock. Until it has finished, packets are not counted and bus writes to counters are dropped. A flat word-addressed register bus reads and writes the table and every counter. It also reads a completion flag.

Top module: `portmap_stats`

## Requirements
- R1: Mapping entry k sits at word address k (0x000-0x0FF). Bits [1:0] hold the destination port, bit 2 is the table-class switch and bits [4:3] hold the table class. Read-back returns zero in bits [31:5] whatever was written there.
- R2: One clock after `in_sop`, `out_valid` is 1 for one cycle. `out_port` is the entry's destination. `out_tc` is `in_tc` when the switch bit is 0 and the table class when it is 1. Without `in_sop`, `out_valid` is 0.
- R3: Destination packet counter n = 4*port + class (address 0x100+n) increments by one per counted packet, including on back-to-back packets.
- R4: Destination byte counter n (address 0x110+n) adds `in_len` per counted packet.
- R5: Source k's 48-bit byte counter reads as a low word at 0x200+2k and a 16-bit high word at 0x201+2k, and adds `in_len` per packet from source k.
- R6: Source k's 40-bit packet counter reads as a low word at 0x400+2k and an 8-bit high word at 0x401+2k. Upper bits of the high word read zero.
- R7: `init_done` and bit 0 of address 0x120 read 0 until the 256th rising clock edge after reset is released, and 1 from then on. Every counter reads zero once `init_done` is 1.
- R8: While `init_done` is 0, packets leave all counters unchanged and bus writes to counters are dropped. Mapping outputs still work.
- R9: Every counter wraps to zero at its full width (32, 48 or 40 bits).
- R10: When a bus write and a packet update hit the same counter in one cycle, the counter takes the written value and the update is lost. The other counters still update.
- R11: `bus_rdata` carries the addressed word in the cycle after `bus_re` and is zero otherwise. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sop | input | 1 | Start-of-packet strobe, one per packet |
| in_src | input | 8 | Source port of the packet |
| in_tc | input | 2 | Traffic class carried by the status word |
| in_len | input | 14 | Packet length in bytes |
| out_valid | output | 1 | Mapping result valid |
| out_port | output | 2 | Chosen destination port |
| out_tc | output | 2 | Chosen traffic class |
| bus_addr | input | 11 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| init_done | output | 1 | Counter clearing complete |

## Verification
The case that is hardest to reach from the ports is a packet, or a counter write, arriving while the clearing sequencer is still running. The effect only shows up once the slot has already been cleared; if it arrives before that, the clearing hides it. The bench waits until the destination slots and the chosen source slot have been cleared but the sequencer is still busy. It then injects one packet and one counter write. After completion it confirms that both counters read zero. The write-versus-update collision is driven by putting a packet strobe and a bus write to the counter that packet selects on the same clock edge.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int DST_W  = 2;
  localparam int TC_W   = 2;
  localparam int WORD_W = 32;

  // field order matters: bits [4:3] table class, [2] switch, [1:0] port
  typedef struct packed {
    logic [TC_W-1:0]  tbl_tc;
    logic             tc_from_tbl;
    logic [DST_W-1:0] dst;
  } map_entry_t;

  localparam int ENTRY_W = $bits(map_entry_t);

  typedef enum logic [2:0] {
    RG_NONE, RG_MAP, RG_DPKT, RG_DBYTE, RG_DONE, RG_SBYTE, RG_SPKT
  } region_e;

  function automatic logic [TC_W-1:0] pick_tc(input map_entry_t e,
                                              input logic [TC_W-1:0] stw_tc);
    return e.tc_from_tbl ? e.tbl_tc : stw_tc;
  endfunction

  // counter slot for a port/class pair: 4*port + class
  function automatic logic [DST_W+TC_W-1:0] queue_slot(input logic [DST_W-1:0] d,
                                                       input logic [TC_W-1:0] t);
    return {d, t};
  endfunction
endpackage

// File: rtl/pms_init_seq.sv
module pms_init_seq #(
  parameter int N  = 256,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] idx,
  output logic          done
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (idx == LAST) done <= 1'b1;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pms_map_table.sv
module pms_map_table
  import pms_pkg::*;
#(
  parameter int N  = 256,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  map_entry_t    wr_entry,
  input  logic [SW-1:0] lk_idx,
  output map_entry_t    lk_entry,
  input  logic [SW-1:0] rd_idx,
  output map_entry_t    rd_entry
);
  map_entry_t tbl [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_entry;
    end
  end

  assign lk_entry = tbl[lk_idx];
  assign rd_entry = tbl[rd_idx];
endmodule

// File: rtl/pms_cnt_bank.sv
module pms_cnt_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int VW    = 1,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_idx,
  input  logic [VW-1:0] inc_val,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_hi,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  input  logic          rd_hi,
  output logic [31:0]   rd_word,
  output logic          inc_apply
);
  logic [WIDTH-1:0] mem [DEPTH];

  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] cur,
                                            input logic [VW-1:0] v);
    return cur + WIDTH'(v);
  endfunction

  // replace one 32-bit word of a counter; a high-word write to a
  // 32-bit counter lands outside the counter and is lost
  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] cur,
                                             input logic hi,
                                             input logic [31:0] d);
    logic [63:0] e;
    e = 64'(cur);
    if (hi) e[63:32] = d;
    else    e[31:0]  = d;
    return e[WIDTH-1:0];
  endfunction

  logic [63:0] rd_ext;

  // a bus write to the same slot wins over the update
  assign inc_apply = inc_en && !(wr_en && (wr_idx == inc_idx));
  assign rd_ext    = 64'(mem[rd_idx]);
  assign rd_word   = rd_hi ? rd_ext[63:32] : rd_ext[31:0];

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_idx] <= '0;
    end else begin
      if (inc_apply) mem[inc_idx] <= bump(mem[inc_idx], inc_val);
      if (wr_en)     mem[wr_idx]  <= merge(mem[wr_idx], wr_hi, wr_data);
    end
  end
endmodule

// File: rtl/portmap_stats.sv
module portmap_stats
  import pms_pkg::*;
#(
  parameter int N_SRC      = 256,
  parameter int LEN_W      = 14,
  parameter int DST_CNT_W  = 32,
  parameter int SRC_BYTE_W = 48,
  parameter int SRC_PKT_W  = 40,
  localparam int SRC_W     = $clog2(N_SRC),
  localparam int AW        = $clog2(6 * N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_sop,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [TC_W-1:0]   in_tc,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  output logic [DST_W-1:0]  out_port,
  output logic [TC_W-1:0]   out_tc,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              init_done
);
  localparam int QW = DST_W + TC_W;
  localparam int NQ = 1 << QW;
  localparam logic [AW:0] A_DPKT  = (AW+1)'(N_SRC);
  localparam logic [AW:0] A_DBYTE = (AW+1)'(N_SRC + NQ);
  localparam logic [AW:0] A_DONE  = (AW+1)'(N_SRC + 2 * NQ);
  localparam logic [AW:0] A_SBYTE = (AW+1)'(2 * N_SRC);
  localparam logic [AW:0] A_SPKT  = (AW+1)'(4 * N_SRC);
  localparam logic [AW:0] A_END   = (AW+1)'(6 * N_SRC);

  function automatic region_e decode_region(input logic [AW:0] a);
    if (a < A_DPKT)                     return RG_MAP;
    else if (a < A_DBYTE)               return RG_DPKT;
    else if (a < A_DONE)                return RG_DBYTE;
    else if (a == A_DONE)               return RG_DONE;
    else if (a >= A_SBYTE && a < A_SPKT) return RG_SBYTE;
    else if (a >= A_SPKT && a < A_END)  return RG_SPKT;
    else                                return RG_NONE;
  endfunction

  // ---------------- bus decode ----------------
  region_e          rg;
  logic [SRC_W-1:0] map_idx;
  logic [QW-1:0]    q_idx;    // bases are multiples of NQ
  logic [SRC_W-1:0] s_idx;    // two words per source, bases multiples of 2*N_SRC
  logic             s_hi;

  assign rg      = decode_region({1'b0, bus_addr});
  assign map_idx = bus_addr[SRC_W-1:0];
  assign q_idx   = bus_addr[QW-1:0];
  assign s_idx   = bus_addr[SRC_W:1];
  assign s_hi    = bus_addr[0];

  // ---------------- init ----------------
  logic [SRC_W-1:0] init_idx;
  logic             dq_clr;
  logic             src_clr;

  pms_init_seq #(.N(N_SRC), .SW(SRC_W)) u_init (
    .clk (clk), .rst (rst), .idx (init_idx), .done (init_done)
  );

  assign src_clr = !init_done;
  assign dq_clr  = !init_done && (init_idx < SRC_W'(NQ));

  // ---------------- mapping ----------------
  map_entry_t      lk_entry;
  map_entry_t      map_rd_entry;
  logic            lk_tc_from_tbl;
  logic [TC_W-1:0] eff_tc;
  logic [QW-1:0]   cnt_q;
  logic            map_wr;
  logic            cnt_go;
  logic            cnt_wr_go;

  assign map_wr = bus_we && (rg == RG_MAP);

  pms_map_table #(.N(N_SRC), .SW(SRC_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (map_wr),
    .wr_idx   (map_idx),
    .wr_entry (map_entry_t'(bus_wdata[ENTRY_W-1:0])),
    .lk_idx   (in_src),
    .lk_entry (lk_entry),
    .rd_idx   (map_idx),
    .rd_entry (map_rd_entry)
  );

  assign lk_tc_from_tbl = lk_entry.tc_from_tbl;
  assign eff_tc         = pick_tc(lk_entry, in_tc);
  assign cnt_q          = queue_slot(lk_entry.dst, eff_tc);
  assign cnt_go         = in_sop && init_done;
  assign cnt_wr_go      = bus_we && init_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_tc    <= '0;
    end else begin
      out_valid <= in_sop;
      if (in_sop) begin
        out_port <= lk_entry.dst;
        out_tc   <= eff_tc;
      end
    end
  end

  // ---------------- counters ----------------
  logic [WORD_W-1:0] dpkt_rd, dbyte_rd, sbyte_rd, spkt_rd;
  logic              dpkt_inc, dbyte_inc, sbyte_inc, spkt_inc;

  pms_cnt_bank #(.DEPTH(NQ), .WIDTH(DST_CNT_W), .VW(1), .IW(QW)) u_dpkt (
    .clk (clk), .clr_en (dq_clr), .clr_idx (init_idx[QW-1:0]),
    .inc_en (cnt_go), .inc_idx (cnt_q), .inc_val (1'b1),
    .wr_en (cnt_wr_go && rg == RG_DPKT), .wr_idx (q_idx), .wr_hi (1'b0),
    .wr_data (bus_wdata), .rd_idx (q_idx), .rd_hi (1'b0),
    .rd_word (dpkt_rd), .inc_apply (dpkt_inc)
  );

  pms_cnt_bank #(.DEPTH(NQ), .WIDTH(DST_CNT_W), .VW(LEN_W), .IW(QW)) u_dbyte (
    .clk (clk), .clr_en (dq_clr), .clr_idx (init_idx[QW-1:0]),
    .inc_en (cnt_go), .inc_idx (cnt_q), .inc_val (in_len),
    .wr_en (cnt_wr_go && rg == RG_DBYTE), .wr_idx (q_idx), .wr_hi (1'b0),
    .wr_data (bus_wdata), .rd_idx (q_idx), .rd_hi (1'b0),
    .rd_word (dbyte_rd), .inc_apply (dbyte_inc)
  );

  pms_cnt_bank #(.DEPTH(N_SRC), .WIDTH(SRC_BYTE_W), .VW(LEN_W), .IW(SRC_W)) u_sbyte (
    .clk (clk), .clr_en (src_clr), .clr_idx (init_idx),
    .inc_en (cnt_go), .inc_idx (in_src), .inc_val (in_len),
    .wr_en (cnt_wr_go && rg == RG_SBYTE), .wr_idx (s_idx), .wr_hi (s_hi),
    .wr_data (bus_wdata), .rd_idx (s_idx), .rd_hi (s_hi),
    .rd_word (sbyte_rd), .inc_apply (sbyte_inc)
  );

  pms_cnt_bank #(.DEPTH(N_SRC), .WIDTH(SRC_PKT_W), .VW(1), .IW(SRC_W)) u_spkt (
    .clk (clk), .clr_en (src_clr), .clr_idx (init_idx),
    .inc_en (cnt_go), .inc_idx (in_src), .inc_val (1'b1),
    .wr_en (cnt_wr_go && rg == RG_SPKT), .wr_idx (s_idx), .wr_hi (s_hi),
    .wr_data (bus_wdata), .rd_idx (s_idx), .rd_hi (s_hi),
    .rd_word (spkt_rd), .inc_apply (spkt_inc)
  );

  // ---------------- read data ----------------
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    unique case (rg)
      RG_MAP:   rd_mux = WORD_W'(map_rd_entry);
      RG_DPKT:  rd_mux = dpkt_rd;
      RG_DBYTE: rd_mux = dbyte_rd;
      RG_DONE:  rd_mux = WORD_W'(init_done);
      RG_SBYTE: rd_mux = sbyte_rd;
      RG_SPKT:  rd_mux = spkt_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_mux : '0;
  end
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int N_SRC = 256,
  parameter int AW    = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        in_sop,
  input logic [1:0]  in_tc,
  input logic        lk_tc_from_tbl,
  input logic        out_valid,
  input logic [1:0]  out_tc,
  input logic        bus_re,
  input logic [AW-1:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        init_done
);
  localparam int CW = $clog2(N_SRC + 1);
  localparam logic [CW-1:0] CNT_LIM = CW'(N_SRC);
  localparam logic [AW-1:0] MAP_END = AW'(N_SRC);

  logic [CW-1:0] edges;

  always_ff @(posedge clk) begin
    if (rst)                   edges <= '0;
    else if (edges != CNT_LIM) edges <= edges + 1'b1;
  end

  a_r1_map_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr < MAP_END) |=> (bus_rdata[31:5] == '0));

  a_r2_valid_after_sop: assert property (@(posedge clk) disable iff (rst)
    in_sop |=> out_valid);

  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_sop |=> !out_valid);

  a_r2_status_class: assert property (@(posedge clk) disable iff (rst)
    (in_sop && !lk_tc_from_tbl) |=> (out_tc == $past(in_tc)));

  a_r7_done_timing: assert property (@(posedge clk) disable iff (rst)
    init_done == (edges == CNT_LIM));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind portmap_stats pms_checker #(.N_SRC(N_SRC), .AW(AW)) u_pms_checker (
  .clk            (clk),
  .rst            (rst),
  .in_sop         (in_sop),
  .in_tc          (in_tc),
  .lk_tc_from_tbl (lk_tc_from_tbl),
  .out_valid      (out_valid),
  .out_tc         (out_tc),
  .bus_re         (bus_re),
  .bus_addr       (bus_addr),
  .bus_rdata      (bus_rdata),
  .init_done      (init_done)
);

// File: tb/portmap_stats_bench.sv
module portmap_stats_bench;
  localparam int N = 256;
  localparam int A_DPKT = N, A_DBYTE = N + 16, A_DONE = N + 32;
  localparam int A_SBYTE = 2 * N, A_SPKT = 4 * N;
  localparam longint unsigned M32 = 64'hFFFF_FFFF;
  localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;
  localparam longint unsigned M48 = 64'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_sop = 1'b0;
  logic [7:0]  in_src = '0;
  logic [1:0]  in_tc = '0;
  logic [13:0] in_len = '0;
  logic        out_valid;
  logic [1:0]  out_port, out_tc;
  logic [10:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        init_done;

  portmap_stats u_portmap_stats (
    .clk (clk), .rst (rst), .in_sop (in_sop), .in_src (in_src),
    .in_tc (in_tc), .in_len (in_len), .out_valid (out_valid),
    .out_port (out_port), .out_tc (out_tc), .bus_addr (bus_addr),
    .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_re (bus_re),
    .bus_rdata (bus_rdata), .init_done (init_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int unsigned edges;
  always_ff @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  logic [4:0]      ent [N];
  longint unsigned dpk [16], dby [16], sby [N], spk [N];

  function automatic logic [4:0] ent_of(input int k);
    return 5'((k * 13 + (k >> 3)) ^ (k >> 5));
  endfunction

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 11'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 11'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input int a, input longint unsigned exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, 64'(d), exp);
  endtask

  // expected queue slot and class for a packet, from the table model
  function automatic int exp_tc(input int s, input logic [1:0] t);
    return ent[s][2] ? int'(ent[s][4:3]) : int'(t);
  endfunction

  function automatic int exp_q(input int s, input logic [1:0] t);
    return int'(ent[s][1:0]) * 4 + exp_tc(s, t);
  endfunction

  task automatic model_pkt(input int s, input logic [1:0] t, input int len);
    int q;
    q = exp_q(s, t);
    dpk[q] = (dpk[q] + 1) & M32;
    dby[q] = (dby[q] + longint'(len)) & M32;
    sby[s] = (sby[s] + longint'(len)) & M48;
    spk[s] = (spk[s] + 1) & M40;
  endtask

  task automatic send_sop(input int s, input logic [1:0] t, input int len,
                          input bit counted);
    @(negedge clk);
    in_sop = 1'b1; in_src = 8'(s); in_tc = t; in_len = 14'(len);
    @(negedge clk);
    in_sop = 1'b0;
    check("R2 valid", 64'(out_valid), 1);
    check("R2 port", 64'(out_port), 64'(ent[s][1:0]));
    check("R2 class", 64'(out_tc), 64'(exp_tc(s, t)));
    if (counted) model_pkt(s, t, len);
  endtask

  task automatic check_counters(input string tag);
    for (int n = 0; n < 16; n++) begin
      read_check({tag, " R3 dst pkt"}, A_DPKT + n, dpk[n]);
      read_check({tag, " R4 dst byte"}, A_DBYTE + n, dby[n]);
    end
    for (int k = 0; k < N; k++) begin
      read_check({tag, " R5 src byte lo"}, A_SBYTE + 2 * k, sby[k] & M32);
      read_check({tag, " R5 src byte hi"}, A_SBYTE + 2 * k + 1, sby[k] >> 32);
      read_check({tag, " R6 src pkt lo"}, A_SPKT + 2 * k, spk[k] & M32);
      read_check({tag, " R6 src pkt hi"}, A_SPKT + 2 * k + 1, spk[k] >> 32);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int s, q;
    for (int k = 0; k < N; k++) begin ent[k] = '0; sby[k] = 0; spk[k] = 0; end
    for (int n = 0; n < 16; n++) begin dpk[n] = 0; dby[n] = 0; end

    repeat (3) @(negedge clk);
    check("R7 reset done", 64'(init_done), 0);
    check("R2 reset valid", 64'(out_valid), 0);
    rst = 1'b0;

    // R8: stimulus once slots are cleared but the sequencer still runs
    while (edges < 40) @(negedge clk);
    send_sop(3, 2'd1, 77, 1'b0);            // entry 3 is zero: port 0, class 1
    bus_write(A_DPKT + 2, 32'hABCD);
    read_check("R7 flag during init", A_DONE, 0);
    check("R8 still initialising", 64'(init_done), 0);

    while (edges < 255) @(negedge clk);
    check("R7 done before edge 256", 64'(init_done), 0);
    @(negedge clk);
    check("R7 done at edge 256", 64'(init_done), 1);
    read_check("R7 flag after init", A_DONE, 1);
    read_check("R8 dropped pkt count", A_DPKT + 1, 0);
    read_check("R8 dropped byte count", A_DBYTE + 1, 0);
    read_check("R8 dropped bus write", A_DPKT + 2, 0);
    read_check("R8 dropped src bytes", A_SBYTE + 6, 0);
    read_check("R8 dropped src pkts", A_SPKT + 6, 0);

    // R1: fill the whole table with junk in the upper bits, read it all back
    for (int k = 0; k < N; k++) begin
      ent[k] = ent_of(k);
      bus_write(k, {27'(k * 37 + 5), ent[k]});
    end
    for (int k = 0; k < N; k++) read_check("R1 table readback", k, 64'(ent[k]));

    // R2..R6: one packet per source, varied class and length
    for (int k = 0; k < N; k++)
      send_sop(k, 2'(k ^ (k >> 4)), (k * 29 + 1) & 16'h3FFF, 1'b1);

    // R3: back-to-back packets on one source
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      in_sop = 1'b1; in_src = 8'd5; in_tc = 2'(i); in_len = 14'(100 + i);
      model_pkt(5, 2'(i), 100 + i);
      @(negedge clk);
    end
    in_sop = 1'b0;
    check_counters("sweep");

    // R9: wrap every counter type
    s = 10;
    q = exp_q(s, 2'd2);
    bus_write(A_DPKT + q, 32'hFFFF_FFFF);  dpk[q] = M32;
    bus_write(A_DBYTE + q, 32'hFFFF_FFFF); dby[q] = M32;
    bus_write(A_SBYTE + 2 * s, 32'hFFFF_FFFF);
    bus_write(A_SBYTE + 2 * s + 1, 32'hFFFF_FFFF); sby[s] = M48;
    bus_write(A_SPKT + 2 * s, 32'hFFFF_FFFF);
    bus_write(A_SPKT + 2 * s + 1, 32'hFFFF_FFFF); spk[s] = M40;
    read_check("R5 byte hi width", A_SBYTE + 2 * s + 1, 64'hFFFF);
    read_check("R6 pkt hi width", A_SPKT + 2 * s + 1, 64'hFF);
    send_sop(s, 2'd2, 2, 1'b1);
    read_check("R9 dst pkt wrap", A_DPKT + q, 0);
    read_check("R9 dst byte wrap", A_DBYTE + q, 1);
    read_check("R9 src byte wrap lo", A_SBYTE + 2 * s, 1);
    read_check("R9 src byte wrap hi", A_SBYTE + 2 * s + 1, 0);
    read_check("R9 src pkt wrap lo", A_SPKT + 2 * s, 0);
    read_check("R9 src pkt wrap hi", A_SPKT + 2 * s + 1, 0);

    // R10: write and update on the same slot in one cycle
    s = 20;
    q = exp_q(s, 2'd3);
    @(negedge clk);
    in_sop = 1'b1; in_src = 8'(s); in_tc = 2'd3; in_len = 14'd9;
    bus_addr = 11'(A_DPKT + q); bus_wdata = 32'h55; bus_we = 1'b1;
    @(negedge clk);
    in_sop = 1'b0; bus_we = 1'b0;
    model_pkt(s, 2'd3, 9);
    dpk[q] = 64'h55;
    read_check("R10 write wins dst pkt", A_DPKT + q, dpk[q]);
    read_check("R10 neighbour byte counted", A_DBYTE + q, dby[q]);
    read_check("R10 neighbour src pkt counted", A_SPKT + 2 * s, spk[s] & M32);

    @(negedge clk);
    in_sop = 1'b1; in_src = 8'(s); in_tc = 2'd3; in_len = 14'd9;
    bus_addr = 11'(A_SBYTE + 2 * s); bus_wdata = 32'h77; bus_we = 1'b1;
    @(negedge clk);
    in_sop = 1'b0; bus_we = 1'b0;
    model_pkt(s, 2'd3, 9);
    sby[s] = (sby[s] & ~M32 & M48) | 64'h77;
    read_check("R10 write wins src byte lo", A_SBYTE + 2 * s, 64'h77);
    read_check("R10 src byte hi kept", A_SBYTE + 2 * s + 1, sby[s] >> 32);
    read_check("R10 dst pkt counted", A_DPKT + q, dpk[q]);

    // R11: unmapped reads and idle read data
    read_check("R11 gap after flag", A_DONE + 1, 0);
    read_check("R11 gap before src", A_SBYTE - 1, 0);
    read_check("R11 beyond map", 6 * N, 0);
    @(negedge clk);
    check("R11 idle rdata", 64'(bus_rdata), 0);
    check("R2 idle valid", 64'(out_valid), 0);
    check_counters("final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule